// File: doc/BRIEF.md
# Duplex Self-Checking Output Selector

This block turns two detect-only self-checking copies of a functional unit into a pair that corrects a fault. Each copy delivers a data result together with the verdict of its own code checker. The selector forwards the result of a copy whose checker is satisfied, and it reports which copy has been caught misbehaving. When no copy can be trusted in a cycle, it keeps the last good output and raises an uncorrectable indication.

Each checker verdict is a set of two-rail pairs. A pair is healthy only when its two bits differ. Both the output and all status are registered, so the choice made from the inputs of one cycle appears after the next rising clock edge. A copy that has been marked as failed is never forwarded again until reset, even if its checker later looks clean. This guards against intermittent faults. The selector never compares the two data words, so a wrong result that its checker does not flag passes straight through.

Top module: `dsc_duplex_sel`

## Requirements
- R1: Checker pair i sits at bits [2i+1:2i] of a copy's check input. The pair is healthy when its two bits differ (01 or 10). A value of 00 or 11 in any pair marks that copy as erroring for the cycle.
- R2: When neither copy errors and neither is marked failed, the next edge loads the primary copy's result into out_data. It also sets out_src to the primary index and clears uncorr. out_src is 0 for copy A and 1 for copy B, and the primary is copy A by default. Data values are never compared.
- R3: When exactly one copy errors and the other copy is usable, the next edge forwards the other copy's result and sets out_src to that copy.
- R4: When exactly one copy errors, the failed flag of that copy is set at the next edge. It stays set until reset.
- R5: A copy whose failed flag is set is treated as unusable from then on. This holds even when its checker is clean.
- R6: When neither copy is usable, the next edge keeps out_data and out_src unchanged and sets uncorr. If both copies error in the same cycle, neither failed flag is set by that cycle.
- R7: uncorr is not sticky. It clears at the next edge after a cycle in which some copy is usable.
- R8: A synchronous active-high reset sets out_data to RESET_VAL (zero by default), sets out_src to the primary index, and clears both failed flags and uncorr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_res | input | DATA_W | Result of copy A |
| a_chk | input | 2*CHK_PAIRS | Two-rail checker verdict of copy A |
| b_res | input | DATA_W | Result of copy B |
| b_chk | input | 2*CHK_PAIRS | Two-rail checker verdict of copy B |
| out_data | output | DATA_W | Registered selected result |
| out_src | output | 1 | Copy that supplied out_data (0 = A, 1 = B) |
| fail_a | output | 1 | Sticky: copy A was caught erroring alone |
| fail_b | output | 1 | Sticky: copy B was caught erroring alone |
| uncorr | output | 1 | No copy was usable in the previous cycle |

## Verification
The assertions watch several rules on every cycle: the failed flags stay set, the output is held whenever uncorr is set, out_src points away from a copy that alone has failed, a clean pair selects the primary copy, and reset clears the status. Other behaviour needs chosen stimulus and can only be shown by the bench's scenarios. That includes the decoding of each illegal two-rail code in each pair position, the exclusion of a failed copy that has since turned clean, the freezing of the output across a double fault, and recovery after a mid-run reset.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   // Which copy drives the output
   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } dsc_src_e;

   // Registered status bundle
   typedef struct packed {
      logic fail_a;
      logic fail_b;
      logic uncorr;
   } dsc_status_t;

   function automatic dsc_src_e dsc_prim_src(input int prim);
      return (prim == 0) ? SRC_A : SRC_B;
   endfunction

endpackage

// File: rtl/dsc_rail_decode.sv
// Reduces a bundle of two-rail pairs to one error bit.
module dsc_rail_decode #(
   parameter int CHK_PAIRS = 2
) (
   input  logic [2*CHK_PAIRS-1:0] rails,
   output logic                   bad
);
   logic [CHK_PAIRS-1:0] pair_bad;

   generate
      for (genvar gi = 0; gi < CHK_PAIRS; gi++) begin : g_pair
         // a pair is healthy only when its rails differ
         assign pair_bad[gi] = ~(rails[2*gi] ^ rails[2*gi+1]);
      end
   endgenerate

   assign bad = |pair_bad;
endmodule

// File: rtl/dsc_sel_ctrl.sv
// Decides the source copy and keeps the sticky status.
module dsc_sel_ctrl
   import dsc_pkg::*;
#(
   parameter int PRIMARY = 0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        err_a,
   input  logic        err_b,
   output logic        load,
   output dsc_src_e    pick,
   output dsc_src_e    src_q,
   output dsc_status_t stat_q
);
   localparam dsc_src_e PRIM_SRC = dsc_prim_src(PRIMARY);

   logic use_a;
   logic use_b;

   assign use_a = ~err_a & ~stat_q.fail_a;
   assign use_b = ~err_b & ~stat_q.fail_b;
   assign load  = use_a | use_b;

   generate
      if (PRIMARY == 0) begin : g_prim_a
         always_comb pick = use_a ? SRC_A : SRC_B;
      end else begin : g_prim_b
         always_comb pick = use_b ? SRC_B : SRC_A;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         src_q  <= PRIM_SRC;
         stat_q <= '0;
      end else begin
         if (load) begin
            src_q <= pick;
         end
         stat_q.uncorr <= ~load;
         if (err_a && !err_b) begin
            stat_q.fail_a <= 1'b1;
         end
         if (err_b && !err_a) begin
            stat_q.fail_b <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dsc_out_reg.sv
// Output register: loads the picked copy or keeps the last good word.
module dsc_out_reg
   import dsc_pkg::*;
#(
   parameter int                DATA_W    = 16,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  dsc_src_e          pick,
   input  logic [DATA_W-1:0] a_res,
   input  logic [DATA_W-1:0] b_res,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] mux_d;

   assign mux_d = (pick == SRC_B) ? b_res : a_res;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RESET_VAL;
      end else if (load) begin
         q <= mux_d;
      end
   end
endmodule

// File: rtl/dsc_duplex_sel.sv
module dsc_duplex_sel
   import dsc_pkg::*;
#(
   parameter int                DATA_W    = 16,
   parameter int                CHK_PAIRS = 2,
   parameter int                PRIMARY   = 0,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [DATA_W-1:0]      a_res,
   input  logic [2*CHK_PAIRS-1:0] a_chk,
   input  logic [DATA_W-1:0]      b_res,
   input  logic [2*CHK_PAIRS-1:0] b_chk,
   output logic [DATA_W-1:0]      out_data,
   output logic                   out_src,
   output logic                   fail_a,
   output logic                   fail_b,
   output logic                   uncorr
);
   localparam int RAIL_W = 2 * CHK_PAIRS;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dsc_duplex_sel: DATA_W must be at least 1");
      end
      if (CHK_PAIRS < 1) begin : g_bad_pairs
         $error("dsc_duplex_sel: CHK_PAIRS must be at least 1");
      end
      if (PRIMARY != 0 && PRIMARY != 1) begin : g_bad_prim
         $error("dsc_duplex_sel: PRIMARY must be 0 or 1");
      end
   endgenerate

   logic [1:0]        err;
   logic              load;
   dsc_src_e          pick;
   dsc_src_e          src_q;
   dsc_status_t       stat_q;
   logic [RAIL_W-1:0] rails [2];

   assign rails[0] = a_chk;
   assign rails[1] = b_chk;

   generate
      for (genvar gc = 0; gc < 2; gc++) begin : g_copy
         dsc_rail_decode #(.CHK_PAIRS(CHK_PAIRS)) u_dec (
            .rails (rails[gc]),
            .bad   (err[gc])
         );
      end
   endgenerate

   dsc_sel_ctrl #(.PRIMARY(PRIMARY)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .err_a  (err[0]),
      .err_b  (err[1]),
      .load   (load),
      .pick   (pick),
      .src_q  (src_q),
      .stat_q (stat_q)
   );

   dsc_out_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_out (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .pick  (pick),
      .a_res (a_res),
      .b_res (b_res),
      .q     (out_data)
   );

   assign out_src = src_q;
   assign fail_a  = stat_q.fail_a;
   assign fail_b  = stat_q.fail_b;
   assign uncorr  = stat_q.uncorr;
endmodule

// File: rtl/dsc_duplex_sel_chk.sv
module dsc_duplex_sel_chk #(
   parameter int DATA_W    = 16,
   parameter int CHK_PAIRS = 2,
   parameter int PRIMARY   = 0
) (
   input logic                   clk,
   input logic                   rst,
   input logic [2*CHK_PAIRS-1:0] a_chk,
   input logic [2*CHK_PAIRS-1:0] b_chk,
   input logic [DATA_W-1:0]      out_data,
   input logic                   out_src,
   input logic                   fail_a,
   input logic                   fail_b,
   input logic                   uncorr
);
   localparam logic PRIM_BIT = (PRIMARY != 0);

   function automatic logic rails_broken(input logic [2*CHK_PAIRS-1:0] r);
      logic any;
      any = 1'b0;
      for (int i = 0; i < CHK_PAIRS; i++) begin
         if (r[2*i] == r[2*i+1]) any = 1'b1;
      end
      return any;
   endfunction

   logic a_bad;
   logic b_bad;
   assign a_bad = rails_broken(a_chk);
   assign b_bad = rails_broken(b_chk);

   p_fail_a_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      fail_a |=> fail_a);
   p_fail_b_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      fail_b |=> fail_b);
   p_hold_on_uncorr_r6: assert property (@(posedge clk) disable iff (rst)
      uncorr |-> (out_data == $past(out_data)));
   p_src_after_a_fail_r5: assert property (@(posedge clk) disable iff (rst)
      (fail_a && !fail_b) |-> out_src);
   p_src_after_b_fail_r5: assert property (@(posedge clk) disable iff (rst)
      (fail_b && !fail_a) |-> !out_src);
   p_clean_primary_r2: assert property (@(posedge clk) disable iff (rst)
      (!a_bad && !b_bad && !fail_a && !fail_b) |=> (out_src == PRIM_BIT && !uncorr));
   p_single_a_err_r3: assert property (@(posedge clk) disable iff (rst)
      (a_bad && !b_bad && !fail_b) |=> (fail_a && out_src && !uncorr));
   p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> (!fail_a && !fail_b && !uncorr && out_src == PRIM_BIT));
endmodule

bind dsc_duplex_sel dsc_duplex_sel_chk #(
   .DATA_W    (DATA_W),
   .CHK_PAIRS (CHK_PAIRS),
   .PRIMARY   (PRIMARY)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .a_chk    (a_chk),
   .b_chk    (b_chk),
   .out_data (out_data),
   .out_src  (out_src),
   .fail_a   (fail_a),
   .fail_b   (fail_b),
   .uncorr   (uncorr)
);

// File: tb/dsc_duplex_sel_tb.sv
`timescale 1ns/1ps
module dsc_duplex_sel_tb;
   localparam int DW = 16;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] a_res = '0;
   logic [DW-1:0] b_res = '0;
   logic [3:0]    a_chk = 4'b0101;
   logic [3:0]    b_chk = 4'b0101;
   logic [DW-1:0] out_data;
   logic          out_src;
   logic          fail_a;
   logic          fail_b;
   logic          uncorr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   dsc_duplex_sel #(.DATA_W(DW), .CHK_PAIRS(NP)) u_dut (
      .clk(clk), .rst(rst), .a_res(a_res), .a_chk(a_chk),
      .b_res(b_res), .b_chk(b_chk), .out_data(out_data),
      .out_src(out_src), .fail_a(fail_a), .fail_b(fail_b), .uncorr(uncorr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input logic [DW-1:0] a, input logic [3:0] ac,
                        input logic [DW-1:0] b, input logic [3:0] bc);
      a_res = a; a_chk = ac; b_res = b; b_chk = bc;
      step();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      a_chk = 4'b0101; b_chk = 4'b0101;
      step();
      rst = 1'b0;
   endtask

   // R8: reset state
   task automatic t_reset();
      rst = 1'b1;
      a_res = 16'h1234; b_res = 16'h4321;
      step(); step();
      chk("R8 out_data", out_data, 0);
      chk("R8 out_src", out_src, 0);
      chk("R8 flags", {fail_a, fail_b, uncorr}, 0);
      rst = 1'b0;
   endtask

   // R2: both clean, primary A forwarded, no data compare
   task automatic t_clean();
      drive(16'h1111, 4'b0101, 16'h2222, 4'b1010);
      chk("R2 data p1", out_data, 16'h1111);
      chk("R2 src p1", out_src, 0);
      drive(16'hFFFF, 4'b0110, 16'h0000, 4'b1001);
      chk("R2 data p2", out_data, 16'hFFFF);
      chk("R2 flags p2", {fail_a, fail_b, uncorr}, 0);
   endtask

   // R1: each illegal code in each pair position flags copy A
   task automatic t_rail_codes();
      logic [3:0] bad_codes [4] = '{4'b0001, 4'b1111, 4'b0100, 4'b1011};
      for (int k = 0; k < 4; k++) begin
         do_reset();
         drive(16'hA000 + 16'(k), bad_codes[k], 16'hB000 + 16'(k), 4'b1001);
         chk("R1 bad code -> B out", out_data, 16'hB000 + 16'(k));
         chk("R1 bad code -> fail_a", fail_a, 1);
      end
      do_reset();
      drive(16'h0C0C, 4'b1001, 16'h0D0D, 4'b0110);
      chk("R1 legal code keeps A", {fail_a, out_data}, {1'b0, 16'h0C0C});
   endtask

   // R3 R4 R5: copy A fails alone, then stays excluded
   task automatic t_single_a();
      do_reset();
      drive(16'h3333, 4'b0111, 16'h4444, 4'b0101);
      chk("R3 B forwarded", out_data, 16'h4444);
      chk("R3 src B", out_src, 1);
      chk("R4 fail_a set", {fail_a, fail_b}, 2'b10);
      drive(16'h5555, 4'b0101, 16'h6666, 4'b0101);
      chk("R5 failed A excluded", out_data, 16'h6666);
      chk("R4 fail_a sticky", fail_a, 1);
   endtask

   // R3 R4: copy B fails alone
   task automatic t_single_b();
      do_reset();
      drive(16'h7070, 4'b0101, 16'h8080, 4'b0000);
      chk("R3 A forwarded", {out_src, out_data}, {1'b0, 16'h7070});
      chk("R4 fail_b set", {fail_a, fail_b}, 2'b01);
      drive(16'h7171, 4'b1010, 16'h8181, 4'b1010);
      chk("R5 A after B failed", {out_src, out_data}, {1'b0, 16'h7171});
   endtask

   // R6 R7: double fault holds output, then recovery
   task automatic t_both_err();
      do_reset();
      drive(16'h5A5A, 4'b0101, 16'h0000, 4'b0101);
      drive(16'hAAAA, 4'b1111, 16'hBBBB, 4'b0000);
      chk("R6 out held", out_data, 16'h5A5A);
      chk("R6 uncorr set", uncorr, 1);
      chk("R6 no fail flags", {fail_a, fail_b}, 0);
      drive(16'h7777, 4'b0101, 16'h8888, 4'b0101);
      chk("R7 uncorr clears", uncorr, 0);
      chk("R7 data resumes", out_data, 16'h7777);
   endtask

   // R5 R6 R8: both copies failed one after the other, then reset
   task automatic t_all_failed();
      do_reset();
      drive(16'h0A0A, 4'b0000, 16'h0B0B, 4'b0101);
      drive(16'h0C0C, 4'b0101, 16'h0D0D, 4'b1100);
      chk("R6 held with all failed", {out_src, out_data}, {1'b1, 16'h0B0B});
      chk("R6 uncorr all failed", {fail_a, fail_b, uncorr}, 3'b111);
      drive(16'h0E0E, 4'b0101, 16'h0F0F, 4'b0101);
      chk("R5 no usable copy", {uncorr, out_data}, {1'b1, 16'h0B0B});
      rst = 1'b1;
      step();
      chk("R8 mid reset clears", {fail_a, fail_b, uncorr, out_src, out_data}, 0);
      rst = 1'b0;
      drive(16'h1F1F, 4'b0101, 16'h2F2F, 4'b0101);
      chk("R8 A usable after reset", out_data, 16'h1F1F);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1..R8 actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_clean();
      t_rail_codes();
      t_single_a();
      t_single_b();
      t_both_err();
      t_all_failed();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule